// File: doc/BRIEF.md
# Sequential Fixed-Point Non-Restoring Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor. The quotient has N integer bits and F fraction bits. The remainder is N bits wide. To produce the fraction bits, the dividend is widened by F zero bits at its low end before the iteration starts. The division is then an integer division of `dividend * 2^F` by the divisor.

The iteration is non-restoring. Each cycle it shifts the signed partial remainder left by one and brings in the next dividend bit. It then subtracts the divisor if the partial remainder was non-negative, or adds it if the partial remainder was negative. The quotient bit for that cycle is the inverted sign of the new value. After the last quotient bit, one correction cycle adds the divisor back if the remainder is negative.

A caller pulses `start` while the block is idle. The caller then waits for the one-cycle `done` pulse and reads `quotient`, `remainder` and `div_zero`. Those outputs hold their values until the next accepted division completes.

Top module: `frac_nr_div`

## Requirements
- R1: For a nonzero divisor, `quotient` equals floor(dividend * 2^F / divisor), with the low F bits being the fraction (N=4, F=4: 7/3 gives 8'b0010_0101).
- R2: For a nonzero divisor, `remainder` equals (dividend * 2^F) mod divisor and is always smaller than the divisor.
- R3: `done` is high for exactly one cycle. For a nonzero divisor it rises N+F+1 clock edges after the edge that accepts `start`.
- R4: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high, where it is low.
- R5: A `start` given while `busy` is high is ignored. The running division completes with its original operands.
- R6: `quotient`, `remainder` and `div_zero` change only in the cycle where `done` is high, and keep their values otherwise, whatever the operand inputs do.
- R7: A zero divisor finishes at the edge that accepts `start`, with `done` and `div_zero` high, `quotient` all ones and `remainder` equal to the dividend. `div_zero` goes low again when the next nonzero division completes.
- R8: After a synchronous active-high reset, `busy`, `done`, `div_zero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | N | Unsigned dividend, sampled on acceptance |
| divisor | input | N | Unsigned divisor, sampled on acceptance |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last completed division had a zero divisor |
| quotient | output | N+F | Fixed-point quotient, F fraction bits |
| remainder | output | N | Remainder of the scaled division |

## Verification
The table of operand pairs is chosen to reach both signs of the partial remainder and to exercise the final correction:
- Equal operands give an exact result with no fraction.
- A divisor of one gives the largest quotient.
- Dividends smaller than the divisor give results with only fraction bits.
- Pairs that leave a nonzero remainder show whether the correction step restores a negative remainder.

A zero dividend and a zero divisor are tried separately from the table. Two directed tests confirm that a new request while running and operand changes after completion leave the outputs alone.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    localparam int unsigned DEF_INT_BITS  = 4;
    localparam int unsigned DEF_FRAC_BITS = 4;

endpackage

// File: rtl/frac_div_step.sv
module frac_div_step #(
    parameter int unsigned N = 4
) (
    input  logic [N+1:0] part_in,
    input  logic         in_bit,
    input  logic [N-1:0] divisor,
    output logic [N+1:0] part_out,
    output logic         q_bit
);
    logic [N+1:0] shifted;
    logic [N+1:0] dsr_ext;

    always_comb begin
        shifted = {part_in[N:0], in_bit};
        dsr_ext = {2'b00, divisor};
        if (part_in[N+1]) begin
            part_out = shifted + dsr_ext;
        end else begin
            part_out = shifted - dsr_ext;
        end
        q_bit = ~part_out[N+1];
    end
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
    import frac_div_pkg::*;
#(
    parameter int unsigned STEPS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    output div_state_e state
);
    localparam int unsigned CW = $clog2(STEPS + 1);

    logic [CW-1:0] step_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    step_cnt <= '0;
                    if (launch) begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    step_cnt <= step_cnt + 1'b1;
                    if (step_cnt == CW'(STEPS - 1)) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frac_nr_div.sv
module frac_nr_div
    import frac_div_pkg::*;
#(
    parameter int unsigned N = DEF_INT_BITS,
    parameter int unsigned F = DEF_FRAC_BITS
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   dividend,
    input  logic [N-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic           div_zero,
    output logic [N+F-1:0] quotient,
    output logic [N-1:0]   remainder
);
    localparam int unsigned W  = N + F;
    localparam int unsigned PW = N + 2;

    div_state_e    state;
    logic          accept;
    logic          launch;
    logic [W-1:0]  dvd_sh;
    logic [N-1:0]  dsr_q;
    logic [PW-1:0] part_q;
    logic [PW-1:0] part_nx;
    logic [PW-1:0] part_fixed;
    logic          q_bit;
    logic [W-1:0]  quo_acc;

    assign accept = start && (state == ST_IDLE);
    assign launch = accept && (divisor != '0);
    assign busy   = (state != ST_IDLE);

    frac_div_ctrl #(.STEPS(W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .state  (state)
    );

    frac_div_step #(.N(N)) u_step (
        .part_in  (part_q),
        .in_bit   (dvd_sh[W-1]),
        .divisor  (dsr_q),
        .part_out (part_nx),
        .q_bit    (q_bit)
    );

    assign part_fixed = part_q[PW-1] ? (part_q + {2'b00, dsr_q}) : part_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_sh    <= '0;
            dsr_q     <= '0;
            part_q    <= '0;
            quo_acc   <= '0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                if (divisor == '0) begin
                    quotient  <= '1;
                    remainder <= dividend;
                    div_zero  <= 1'b1;
                    done      <= 1'b1;
                end else begin
                    dvd_sh  <= W'(dividend) << F;
                    dsr_q   <= divisor;
                    part_q  <= '0;
                    quo_acc <= '0;
                end
            end else if (state == ST_RUN) begin
                part_q  <= part_nx;
                dvd_sh  <= dvd_sh << 1;
                quo_acc <= {quo_acc[W-2:0], q_bit};
            end else if (state == ST_FIX) begin
                quotient  <= quo_acc;
                remainder <= part_fixed[N-1:0];
                div_zero  <= 1'b0;
                done      <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frac_nr_div_chk.sv
module frac_nr_div_chk #(
    parameter int unsigned N = 4,
    parameter int unsigned F = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [N-1:0]   dividend,
    input logic [N-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic           div_zero,
    input logic [N+F-1:0] quotient,
    input logic [N-1:0]   remainder
);
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor != '0) |=> busy);

    assert_hold_results_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

    assert_zero_quot_R7: assert property (@(posedge clk) disable iff (rst)
        (done && div_zero) |-> (quotient == '1));

    assert_zero_fast_R7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && divisor == '0) |=> (done && div_zero));
endmodule

bind frac_nr_div frac_nr_div_chk #(.N(N), .F(F)) u_chk (.*);

// File: tb/frac_nr_div_bench.sv
module frac_nr_div_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int F = 4;
    localparam int W = N + F;
    localparam int NV = 10;
    // {dividend, divisor, expected quotient, expected remainder}
    localparam logic [19:0] VEC [NV] = '{
        {4'd7,  4'd3,  8'd37,  4'd1},
        {4'd15, 4'd1,  8'd240, 4'd0},
        {4'd1,  4'd15, 8'd1,   4'd1},
        {4'd15, 4'd15, 8'd16,  4'd0},
        {4'd9,  4'd4,  8'd36,  4'd0},
        {4'd5,  4'd7,  8'd11,  4'd3},
        {4'd13, 4'd6,  8'd34,  4'd4},
        {4'd15, 4'd2,  8'd120, 4'd0},
        {4'd1,  4'd1,  8'd16,  4'd0},
        {4'd3,  4'd11, 8'd4,   4'd4}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [N-1:0] dividend = '0;
    logic [N-1:0] divisor = '0;
    logic         busy, done, div_zero;
    logic [W-1:0] quotient;
    logic [N-1:0] remainder;

    int checks = 0;
    int errors = 0;
    int lat;
    logic first_busy;

    frac_nr_div #(.N(N), .F(F)) u_frac_nr_div (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .div_zero(div_zero),
        .quotient(quotient), .remainder(remainder)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_div(input logic [N-1:0] a, input logic [N-1:0] b);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_busy = busy;
        lat = 0;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(busy == 0 && done == 0 && div_zero == 0, "R8 flags", {busy, done, div_zero}, 0);
        check(quotient == 0 && remainder == 0, "R8 results", quotient, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_div(VEC[i][19:16], VEC[i][15:12]);
            check(quotient == VEC[i][11:4], "R1 quotient", quotient, VEC[i][11:4]);
            check(remainder == VEC[i][3:0], "R2 remainder", remainder, VEC[i][3:0]);
            check(lat == W + 1, "R3 latency", lat, W + 1);
            check(first_busy == 1'b1 && busy == 1'b0, "R4 busy", {first_busy, busy}, 2);
            @(negedge clk);
            check(done == 1'b0, "R3 single pulse", done, 0);
        end

        // R7: zero divisor
        run_div(4'd9, 4'd0);
        check(lat == 0, "R7 latency", lat, 0);
        check(div_zero == 1'b1, "R7 flag", div_zero, 1);
        check(quotient == 8'hFF && remainder == 4'd9, "R7 results", quotient, 255);

        // R7: flag clears after a valid division; zero dividend
        run_div(4'd0, 4'd5);
        check(div_zero == 1'b0, "R7 flag clear", div_zero, 0);
        check(quotient == 0 && remainder == 0, "R1 zero dividend", quotient, 0);

        // R5: start while busy is ignored
        @(negedge clk);
        dividend = 4'd7; divisor = 4'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        dividend = 4'd15; divisor = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        check(quotient == 8'd37 && remainder == 4'd1, "R5 ignored start", quotient, 37);
        @(negedge clk);
        check(busy == 1'b0, "R5 no second run", busy, 0);

        // R6: operand changes without start leave results alone
        dividend = 4'd2; divisor = 4'd0;
        repeat (W + 4) @(negedge clk);
        check(quotient == 8'd37 && remainder == 4'd1 && div_zero == 0, "R6 hold", quotient, 37);
        check(done == 1'b0 && busy == 1'b0, "R6 idle", {done, busy}, 0);

        finish_run();
    end
endmodule